// File: doc/BRIEF.md
# Keyed Configuration Register Space

This block is a configuration register space that a host reaches through two byte-wide I/O ports: an index port and a data port. After reset the space is locked. The host opens it by writing a fixed key byte to the index port twice in succession, and closes it again with a separate closing key. While the space is open, a write to the index port chooses a register, and accesses to the data port then read or write that register.

A logical-device register selects one of several identical device banks. Each bank holds an enable bit, a 16-bit I/O base and a 4-bit interrupt line, all driven out as plain configuration outputs. A small set of global registers returns fixed chip and vendor identification. One bank, the infrared device, also reports a read-only capability class code.

The I/O side carries no back-pressure. The block accepts one access in any cycle where `io_valid` is high. A read access returns its byte one cycle later with `io_rvalid` high for exactly one cycle. The host may issue accesses back to back.

Top module: `cfgk_space`

## Requirements
- R1: A synchronous active-high `rst` locks the space. It also clears the selected index, the logical device number, and every bank's enable, base and interrupt line to zero.
- R2: The space opens only after two consecutive index-port writes of 0x87. Data-port accesses do not break the sequence. Any other index-port value written while locked restarts it. `cfg_open` goes high one cycle after the second key write.
- R3: An index-port write of 0xAA while open locks the space from the next cycle. The closing key does not change the selected index.
- R4: While locked, data-port and index-port reads return 0xFF. Data-port writes change no register.
- R5: Every read access (io_valid=1, io_write=0) gives io_rvalid=1 with its data one cycle later. io_rvalid is 0 in every other cycle.
- R6: Register 0x07 holds the logical device number (read/write, 8 bits). Registers at 0x30 and above access the bank of that device. When the number is not below NUM_DEV, those registers read 0x00 and ignore writes.
- R7: Registers 0x20/0x21 read the chip ID (0x04/0x08). Registers 0x23/0x24 read the vendor ID (0x19/0x34). Writes to them have no effect.
- R8: Bank register 0x30 bit 0 is the device enable and drives `dev_enable[n]`. Its other bits read 0.
- R9: Bank registers 0x60 and 0x61 hold the high and low base byte, driving `dev_base[16n+15:16n]`. Bank register 0x70 bits 3:0 hold the interrupt line, driving `dev_irq[4n+3:4n]`, and its upper bits read 0.
- R10: In the bank of logical device 5, register 0xF0 reads the class code (0xFF receive only, 0x33 receive plus one transmitter, 0x66 receive plus two; default 0x33) and ignores writes. In all other banks it reads 0x00.
- R11: While open, an index-port read returns the selected index, and every unmapped register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | Access strobe, one access per cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 1 | 0 = index port, 1 = data port |
| io_wdata | input | 8 | Write byte |
| io_rvalid | output | 1 | Read data valid, one cycle after a read |
| io_rdata | output | 8 | Read byte |
| cfg_open | output | 1 | Space is unlocked |
| dev_enable | output | NUM_DEV | Per-device enable |
| dev_base | output | 16*NUM_DEV | Per-device I/O base, device n at bits 16n+15:16n |
| dev_irq | output | 4*NUM_DEV | Per-device interrupt line, device n at bits 4n+3:4n |

## Verification
On every cycle, the embedded properties check several behaviours. Locked reads return 0xFF. Locked writes leave the logical device number and the bank outputs untouched. The closing key always drops `cfg_open`. The space never opens except directly after an opening key write. Every read gets exactly one `io_rvalid` pulse. Other behaviours need the bench scenarios: the exact contents of the whole register map under a given device selection, the routing of writes to the correct bank, the read-only nature of the identification and class registers, and the way a stray value breaks the key sequence.

// File: rtl/cfgk_pkg.sv
package cfgk_pkg;
  localparam logic [7:0] KEY_OPEN   = 8'h87;
  localparam logic [7:0] KEY_CLOSE  = 8'hAA;
  localparam logic [7:0] LOCKED_RD  = 8'hFF;

  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_CHIP_HI = 8'h20;
  localparam logic [7:0] REG_CHIP_LO = 8'h21;
  localparam logic [7:0] REG_VEND_HI = 8'h23;
  localparam logic [7:0] REG_VEND_LO = 8'h24;
  localparam logic [7:0] BANK_FIRST  = 8'h30;
  localparam logic [7:0] REG_ENABLE  = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;
  localparam logic [7:0] REG_IRQ     = 8'h70;
  localparam logic [7:0] REG_CLASS   = 8'hF0;

  localparam int IRQ_W  = 4;
  localparam int BASE_W = 16;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;
endpackage

// File: rtl/cfgk_unlock.sv
module cfgk_unlock
  import cfgk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic       idx_load
);
  key_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata == KEY_OPEN)  ? KS_ARMED  : KS_LOCKED;
        KS_ARMED:  state_d = (wdata == KEY_OPEN)  ? KS_OPEN   : KS_LOCKED;
        KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KS_LOCKED;
    else     state_q <= state_d;
  end

  assign cfg_open = (state_q == KS_OPEN);
  assign idx_load = cfg_open && idx_wr && (wdata != KEY_CLOSE);

  // R2: opening must be caused by an opening key write in the cycle before
  assert_open_after_key_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_open) |-> $past(idx_wr && wdata == KEY_OPEN));
endmodule

// File: rtl/cfgk_bank.sv
module cfgk_bank
  import cfgk_pkg::*;
#(
  parameter bit         HAS_CLASS  = 1'b0,
  parameter logic [7:0] CLASS_CODE = 8'h33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        reg_idx,
  input  logic [7:0]        wdata,
  output logic              en,
  output logic [BASE_W-1:0] base,
  output logic [IRQ_W-1:0]  irq,
  output logic [7:0]        rd_data
);
  logic [7:0] class_val;

  generate
    if (HAS_CLASS) begin : g_class
      assign class_val = CLASS_CODE;
    end else begin : g_noclass
      assign class_val = 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      base <= '0;
      irq  <= '0;
    end else if (wr_en) begin
      unique case (reg_idx)
        REG_ENABLE:  en          <= wdata[0];
        REG_BASE_HI: base[15:8]  <= wdata;
        REG_BASE_LO: base[7:0]   <= wdata;
        REG_IRQ:     irq         <= wdata[IRQ_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (reg_idx)
      REG_ENABLE:  rd_data = {7'b0, en};
      REG_BASE_HI: rd_data = base[15:8];
      REG_BASE_LO: rd_data = base[7:0];
      REG_IRQ:     rd_data = {{(8-IRQ_W){1'b0}}, irq};
      REG_CLASS:   rd_data = class_val;
      default:     rd_data = 8'h00;
    endcase
  end

  // R8: bank state only moves when this bank is written
  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(en) && $stable(base) && $stable(irq)));
endmodule

// File: rtl/cfgk_space.sv
module cfgk_space
  import cfgk_pkg::*;
#(
  parameter int          NUM_DEV    = 8,
  parameter int          LDN_IR     = 5,
  parameter logic [15:0] CHIP_ID    = 16'h0408,
  parameter logic [15:0] VENDOR_ID  = 16'h1934,
  parameter logic [7:0]  IR_CLASS   = 8'h33
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      io_valid,
  input  logic                      io_write,
  input  logic                      io_port,
  input  logic [7:0]                io_wdata,
  output logic                      io_rvalid,
  output logic [7:0]                io_rdata,
  output logic                      cfg_open,
  output logic [NUM_DEV-1:0]        dev_enable,
  output logic [NUM_DEV*BASE_W-1:0] dev_base,
  output logic [NUM_DEV*IRQ_W-1:0]  dev_irq
);
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic       idx_wr, dat_wr, any_rd, idx_load;
  logic [7:0] index_q, ldn_q, rd_mux;
  logic       in_bank, ldn_hit;
  logic [7:0] bank_rd [NUM_DEV];

  assign idx_wr = io_valid && io_write && !io_port;
  assign dat_wr = io_valid && io_write && io_port && cfg_open;
  assign any_rd = io_valid && !io_write;

  cfgk_unlock u_unlock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .idx_load (idx_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
    end else begin
      if (idx_load) index_q <= io_wdata;
      if (dat_wr && index_q == REG_LDN) ldn_q <= io_wdata;
    end
  end

  assign in_bank = (index_q >= BANK_FIRST);
  assign ldn_hit = (32'(ldn_q) < NUM_DEV);

  generate
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      cfgk_bank #(
        .HAS_CLASS  (d == LDN_IR),
        .CLASS_CODE (IR_CLASS)
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dat_wr && in_bank && (ldn_q == 8'(d))),
        .reg_idx (index_q),
        .wdata   (io_wdata),
        .en      (dev_enable[d]),
        .base    (dev_base[d*BASE_W +: BASE_W]),
        .irq     (dev_irq[d*IRQ_W +: IRQ_W]),
        .rd_data (bank_rd[d])
      );
    end
  endgenerate

  always_comb begin
    rd_mux = 8'h00;
    if (!cfg_open) begin
      rd_mux = LOCKED_RD;
    end else if (!io_port) begin
      rd_mux = index_q;
    end else begin
      unique case (index_q)
        REG_LDN:     rd_mux = ldn_q;
        REG_CHIP_HI: rd_mux = CHIP_ID[15:8];
        REG_CHIP_LO: rd_mux = CHIP_ID[7:0];
        REG_VEND_HI: rd_mux = VENDOR_ID[15:8];
        REG_VEND_LO: rd_mux = VENDOR_ID[7:0];
        default:
          if (in_bank && ldn_hit) rd_mux = bank_rd[ldn_q[DEV_W-1:0]];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= 8'h00;
    end else begin
      io_rvalid <= any_rd;
      if (any_rd) io_rdata <= rd_mux;
    end
  end

  // R5: one data-valid pulse per read, none otherwise
  assert_rvalid_per_read_R5: assert property (@(posedge clk) disable iff (rst)
    any_rd |=> io_rvalid);
  assert_rvalid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !any_rd |=> !io_rvalid);
  // R4: locked reads return all ones
  assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (rst)
    (any_rd && !cfg_open) |=> (io_rdata == LOCKED_RD));
  // R4: locked writes leave configuration untouched
  assert_locked_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_open && io_valid && io_write && io_port) |=>
      ($stable(ldn_q) && $stable(dev_enable) && $stable(dev_base) && $stable(dev_irq)));
  // R3: closing key locks the space
  assert_close_key_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_open && idx_wr && io_wdata == KEY_CLOSE) |=> (!cfg_open && $stable(index_q)));
endmodule

// File: tb/cfgk_space_test.sv
`timescale 1ns/1ps
module cfgk_space_test;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_valid = 1'b0, io_write = 1'b0, io_port = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic io_rvalid;
  logic [7:0] io_rdata;
  logic cfg_open;
  logic [ND-1:0] dev_enable;
  logic [ND*16-1:0] dev_base;
  logic [ND*4-1:0] dev_irq;

  int checks = 0;
  int errors = 0;

  logic       m_en   [ND];
  logic [15:0] m_base [ND];
  logic [3:0] m_irq  [ND];

  always #2 clk = ~clk;

  cfgk_space uut (
    .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_wdata(io_wdata), .io_rvalid(io_rvalid),
    .io_rdata(io_rdata), .cfg_open(cfg_open), .dev_enable(dev_enable),
    .dev_base(dev_base), .dev_irq(dev_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic port, input logic [7:0] v);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b1; io_port = port; io_wdata = v;
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic rd(input logic port, output logic [7:0] v, output logic vld);
    @(negedge clk);
    io_valid = 1'b1; io_write = 1'b0; io_port = port;
    @(negedge clk);
    io_valid = 1'b0;
    v = io_rdata; vld = io_rvalid;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
    logic vld;
    wr(1'b0, idx);
    rd(1'b1, v, vld);
  endtask

  task automatic open_space();
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h87);
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] idx, input int ldn);
    logic [7:0] r;
    r = 8'h00;
    case (idx)
      8'h07: r = 8'(ldn);
      8'h20: r = 8'h04;
      8'h21: r = 8'h08;
      8'h23: r = 8'h19;
      8'h24: r = 8'h34;
      default:
        if (ldn < ND) begin
          case (idx)
            8'h30: r = {7'b0, m_en[ldn]};
            8'h60: r = m_base[ldn][15:8];
            8'h61: r = m_base[ldn][7:0];
            8'h70: r = {4'b0, m_irq[ldn]};
            8'hF0: r = (ldn == 5) ? 8'h33 : 8'h00;
            default: r = 8'h00;
          endcase
        end
    endcase
    return r;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic vld;
    for (int d = 0; d < ND; d++) begin
      m_en[d] = 1'b0; m_base[d] = 16'h0; m_irq[d] = 4'h0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 open", 32'(cfg_open), 0);
    chk("R1 enable", 32'(dev_enable), 0);
    chk("R1 base", 32'(|dev_base), 0);
    chk("R1 irq", 32'(dev_irq), 0);
    chk("R5 idle rvalid", 32'(io_rvalid), 0);

    // R4: locked reads on both ports
    rd(1'b1, v, vld);
    chk("R4 locked data read", 32'(v), 32'hFF);
    chk("R5 rvalid", 32'(vld), 1);
    rd(1'b0, v, vld);
    chk("R4 locked index read", 32'(v), 32'hFF);

    // R2: second key byte sweep
    for (int k = 0; k < 256; k++) begin
      wr(1'b0, 8'h87);
      wr(1'b0, 8'(k));
      chk("R2 key sweep", 32'(cfg_open), (k == 8'h87) ? 1 : 0);
      if (cfg_open) wr(1'b0, 8'hAA);
    end
    // R2: stray value between keys restarts the sequence
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    chk("R2 interrupted", 32'(cfg_open), 0);
    wr(1'b0, 8'h87);
    chk("R2 restart opens", 32'(cfg_open), 1);
    wr(1'b0, 8'hAA);
    // R2: data-port access between keys does not break sequence
    wr(1'b0, 8'h87); rd(1'b1, v, vld); wr(1'b0, 8'h87);
    chk("R2 data between keys", 32'(cfg_open), 1);

    // R3/R4: close with index at LDN, write data while locked
    wr(1'b0, 8'h07);
    wr(1'b0, 8'hAA);
    chk("R3 closed", 32'(cfg_open), 0);
    wr(1'b1, 8'h03);
    open_space();
    rd(1'b0, v, vld);
    chk("R3 index kept", 32'(v), 32'h07);
    rd(1'b1, v, vld);
    chk("R4 locked write ignored", 32'(v), 32'h00);

    // R7: identification is read-only
    wr(1'b0, 8'h20); wr(1'b1, 8'h55);
    wr(1'b0, 8'h24); wr(1'b1, 8'h55);
    rd_reg(8'h20, v); chk("R7 chip hi", 32'(v), 32'h04);
    rd_reg(8'h21, v); chk("R7 chip lo", 32'(v), 32'h08);
    rd_reg(8'h23, v); chk("R7 vendor hi", 32'(v), 32'h19);
    rd_reg(8'h24, v); chk("R7 vendor lo", 32'(v), 32'h34);

    // R6/R8/R9: program every bank plus two out-of-range numbers
    for (int d = 0; d < ND + 2; d++) begin
      wr(1'b0, 8'h07); wr(1'b1, 8'(d));
      wr(1'b0, 8'h30); wr(1'b1, 8'hFE | 8'(d & 1));
      wr(1'b0, 8'h60); wr(1'b1, 8'(d * 16 + 3));
      wr(1'b0, 8'h61); wr(1'b1, 8'(8'hA0 + d));
      wr(1'b0, 8'h70); wr(1'b1, 8'(8'hF0 + d));
      wr(1'b0, 8'hF0); wr(1'b1, 8'h5A);
      if (d < ND) begin
        m_en[d] = 1'(d & 1);
        m_base[d] = {8'(d * 16 + 3), 8'(8'hA0 + d)};
        m_irq[d] = 4'(d);
      end
    end
    for (int d = 0; d < ND; d++) begin
      chk("R8 enable out", 32'(dev_enable[d]), 32'(m_en[d]));
      chk("R9 base out", 32'(dev_base[d*16 +: 16]), 32'(m_base[d]));
      chk("R9 irq out", 32'(dev_irq[d*4 +: 4]), 32'(m_irq[d]));
    end

    // R6/R10/R11: full register sweep for several device numbers
    foreach (m_en[i]) begin end
    for (int s = 0; s < 4; s++) begin
      int ldn;
      ldn = (s == 0) ? 5 : (s == 1) ? 2 : (s == 2) ? 9 : 0;
      wr(1'b0, 8'h07); wr(1'b1, 8'(ldn));
      for (int i = 0; i < 256; i++) begin
        if (i == 8'hAA) continue;
        rd_reg(8'(i), v);
        chk("R6 R10 R11 map sweep", 32'(v), 32'(exp_reg(8'(i), ldn)));
      end
    end
    wr(1'b0, 8'h61);
    rd(1'b0, v, vld);
    chk("R11 index readback", 32'(v), 32'h61);
    @(negedge clk);
    chk("R5 rvalid single", 32'(io_rvalid), 0);

    // R3: close and confirm locked reads
    wr(1'b0, 8'hAA);
    chk("R3 close", 32'(cfg_open), 0);
    rd(1'b1, v, vld);
    chk("R4 locked after close", 32'(v), 32'hFF);

    // R1: reset clears programmed state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset enable", 32'(dev_enable), 0);
    chk("R1 reset base", 32'(|dev_base), 0);
    chk("R1 reset open", 32'(cfg_open), 0);
    open_space();
    rd_reg(8'h07, v);
    chk("R1 reset ldn", 32'(v), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule